// File: doc/BRIEF.md
# Multithreaded Windowed Integer Register File

This block holds the integer registers of four hardware threads that share one pipeline. Each thread sees 32 architectural registers: eight globals, plus a sliding window of eight outs, eight locals and eight ins. Each thread has eight windows. The outs of one window use the same storage as the ins of the next window up. A procedure call moves a thread's window up by one, and a return moves it down by one. The caller and callee therefore pass arguments through registers without copying them.

There are three combinational read ports and two write ports. Every port carries its own thread ID and a 5-bit register number. Writes take effect at the clock edge, and a read of a location being written in the same cycle returns the new data.

A window command names one thread. It updates that thread's window pointer at the next edge and raises a one-cycle thread-switch request for that thread. A call from the top window or a return from the bottom window does not move the pointer. It raises an overflow or underflow flag instead, and servicing that flag is left to the surrounding logic.

Top module: `mt_window_regfile`

## Requirements
- R1: Each of the three read ports returns, in the same cycle, the value held in the register named by its thread ID and register number, under that thread's current window.
- R2: A write on either port with enable high is visible to reads from the following cycle onward.
- R3: Threads never share register contents: a write to a register of one thread leaves the same register number of every other thread unchanged.
- R4: A call command raises the addressed thread's window pointer by one, and a return lowers it by one. The new value is visible on `cur_win` in the cycle after the command. After reset all pointers are 0.
- R5: A command that moves a window sets bit `tid` of `switch_req` for exactly the next cycle. All other bits stay low, and at most one bit is ever high.
- R6: Register 0 of every thread always reads as zero. Writes to it have no effect.
- R7: A call at window 7 sets `win_ovf`, and a return at window 0 sets `win_unf`, each for the next cycle. In both cases the pointer is left unchanged and no switch request is raised.
- R8: Register numbers 0-7 are globals shared by all windows of a thread. Numbers 8-15 are outs, 16-23 are locals and 24-31 are ins. Out register 8+k of window w is the same storage as in register 24+k of window w+1, and locals are private to their window.
- R9: A read of a location that is being written in the same cycle returns the data being written.
- R10: When both write ports target the same storage location in one cycle, the value from port 1 is stored and bypassed.
- R11: After reset all registers read as zero and `win_ovf`, `win_unf` and `switch_req` are low.
- R12: Reads and writes in the cycle of a window command use the window pointer held before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_tid | input | 3x2 | Thread ID per read port |
| rd_addr | input | 3x5 | Register number per read port |
| rd_data | output | 3x32 | Read data per read port |
| wr_en | input | 2 | Write enable per write port |
| wr_tid | input | 2x2 | Thread ID per write port |
| wr_addr | input | 2x5 | Register number per write port |
| wr_data | input | 2x32 | Write data per write port |
| win_valid | input | 1 | Window command valid |
| win_tid | input | 2 | Thread addressed by the window command |
| win_call | input | 1 | 1 = call (slide up), 0 = return (slide down) |
| cur_win | output | 4x3 | Current window pointer of each thread |
| switch_req | output | 4 | One-cycle thread-switch request per thread |
| win_ovf | output | 1 | Call attempted at the top window |
| win_unf | output | 1 | Return attempted at the bottom window |

## Verification
Directed sequences come first. They write the same register number in two threads, which tells apart a file that keeps threads isolated from one that aliases them. They write an out register, then call and read the matching in, which checks the overlap against a mapping that is off by one group. They drive both write ports onto one location, which shows which port has priority. They also combine a write with a call in the same cycle, to show which window pointer the write used.

A long random walk of calls and returns then repeatedly reaches windows 0 and 7. It mixes this with random reads and writes over all threads and register numbers, so bypass hits, register 0 and window boundaries all occur under traffic.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

    // Register-number group, decoded from bits [4:3] of the architectural number
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_grp_e;

    localparam int GRP_REGS = 8;

endpackage

// File: rtl/rwf_addr_map.sv
// Translates (thread, window, register number) into a flat storage index.
// Per thread: 8 globals, then 2*NWIN+1 groups of eight windowed registers.
// Window w: ins = group 2w, locals = group 2w+1, outs = group 2w+2 (= ins of w+1).
module rwf_addr_map
    import rwf_pkg::*;
#(
    parameter int TW  = 2,
    parameter int WW  = 3,
    parameter int AW  = 10,
    parameter int PER = 144
) (
    input  logic [TW-1:0] tid,
    input  logic [WW-1:0] win,
    input  logic [4:0]    arch,
    output logic [AW-1:0] idx,
    output logic          is_zero
);

    reg_grp_e      grp;
    logic [AW-1:0] slot;
    logic [AW-1:0] off;

    always_comb begin
        grp = reg_grp_e'(arch[4:3]);
        unique case (grp)
            GRP_IN:    slot = AW'(win) << 1;
            GRP_LOCAL: slot = (AW'(win) << 1) + AW'(1);
            GRP_OUT:   slot = (AW'(win) << 1) + AW'(2);
            default:   slot = '0;
        endcase
        off = AW'(arch[2:0]);
        if (grp != GRP_GLOBAL) begin
            off = off + AW'(GRP_REGS) + (slot << 3);
        end
        idx     = AW'(tid) * AW'(PER) + off;
        is_zero = (arch == 5'd0);
    end

endmodule

// File: rtl/rwf_window_ctl.sv
// Per-thread window pointers, switch requests and boundary trap flags.
module rwf_window_ctl #(
    parameter int NTHR = 4,
    parameter int NWIN = 8,
    parameter int TW   = 2,
    parameter int WW   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [TW-1:0]            cmd_tid,
    input  logic                     cmd_call,
    output logic [NTHR-1:0][WW-1:0]  win_o,
    output logic [NTHR-1:0]          switch_o,
    output logic                     ovf_o,
    output logic                     unf_o
);

    localparam logic [WW-1:0] TOP_WIN = WW'(NWIN - 1);

    typedef struct packed {
        logic [NTHR-1:0][WW-1:0] win;
        logic [NTHR-1:0]         sw;
        logic                    ovf;
        logic                    unf;
    } ctl_t;

    ctl_t          st_d, st_q;
    logic [WW-1:0] sel_win;

    always_comb begin
        sel_win  = st_q.win[cmd_tid];
        st_d     = st_q;
        st_d.sw  = '0;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        if (cmd_valid) begin
            if (cmd_call) begin
                if (sel_win == TOP_WIN) begin
                    st_d.ovf = 1'b1;
                end else begin
                    st_d.win[cmd_tid] = sel_win + WW'(1);
                    st_d.sw[cmd_tid]  = 1'b1;
                end
            end else begin
                if (sel_win == '0) begin
                    st_d.unf = 1'b1;
                end else begin
                    st_d.win[cmd_tid] = sel_win - WW'(1);
                    st_d.sw[cmd_tid]  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_o    = st_q.win;
    assign switch_o = st_q.sw;
    assign ovf_o    = st_q.ovf;
    assign unf_o    = st_q.unf;

    p_call_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_call && sel_win != TOP_WIN)
        |=> (win_o[$past(cmd_tid)] == $past(sel_win) + WW'(1)));

    p_ret_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_call && sel_win != '0)
        |=> (win_o[$past(cmd_tid)] == $past(sel_win) - WW'(1)));

    p_one_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(switch_o));

    p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_call && sel_win == TOP_WIN)
        |=> (ovf_o && $stable(win_o) && switch_o == '0));

    p_unf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_call && sel_win == '0)
        |=> (unf_o && $stable(win_o) && switch_o == '0));

endmodule

// File: rtl/mt_window_regfile.sv
module mt_window_regfile #(
    parameter int NTHR = 4,
    parameter int NWIN = 8,
    parameter int DW   = 32,
    parameter int NRD  = 3,
    parameter int NWR  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NRD-1:0][TW-1:0]    rd_tid,
    input  logic [NRD-1:0][4:0]       rd_addr,
    output logic [NRD-1:0][DW-1:0]    rd_data,
    input  logic [NWR-1:0]            wr_en,
    input  logic [NWR-1:0][TW-1:0]    wr_tid,
    input  logic [NWR-1:0][4:0]       wr_addr,
    input  logic [NWR-1:0][DW-1:0]    wr_data,
    input  logic                      win_valid,
    input  logic [TW-1:0]             win_tid,
    input  logic                      win_call,
    output logic [NTHR-1:0][WW-1:0]   cur_win,
    output logic [NTHR-1:0]           switch_req,
    output logic                      win_ovf,
    output logic                      win_unf
);

    localparam int TW    = (NTHR > 1) ? $clog2(NTHR) : 1;
    localparam int WW    = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int PER   = 8 * (2 * NWIN + 2);
    localparam int DEPTH = NTHR * PER;
    localparam int AW    = $clog2(DEPTH);

    logic [NTHR-1:0][WW-1:0] win_q;
    logic [NWR-1:0][AW-1:0]  w_idx;
    logic [NWR-1:0]          w_zero;
    logic [NWR-1:0]          w_act;
    logic [NRD-1:0][AW-1:0]  r_idx;
    logic [NRD-1:0]          r_zero;
    logic [DW-1:0]           mem_q [DEPTH];

    rwf_window_ctl #(.NTHR(NTHR), .NWIN(NWIN), .TW(TW), .WW(WW)) i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (win_valid),
        .cmd_tid   (win_tid),
        .cmd_call  (win_call),
        .win_o     (win_q),
        .switch_o  (switch_req),
        .ovf_o     (win_ovf),
        .unf_o     (win_unf)
    );

    assign cur_win = win_q;

    for (genvar k = 0; k < NWR; k++) begin : g_wmap
        rwf_addr_map #(.TW(TW), .WW(WW), .AW(AW), .PER(PER)) i_map (
            .tid     (wr_tid[k]),
            .win     (win_q[wr_tid[k]]),
            .arch    (wr_addr[k]),
            .idx     (w_idx[k]),
            .is_zero (w_zero[k])
        );
        assign w_act[k] = wr_en[k] && !w_zero[k];
    end

    // Later ports win on a shared location.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int k = 0; k < NWR; k++) begin
                if (w_act[k]) begin
                    mem_q[w_idx[k]] <= wr_data[k];
                end
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        rwf_addr_map #(.TW(TW), .WW(WW), .AW(AW), .PER(PER)) i_map (
            .tid     (rd_tid[p]),
            .win     (win_q[rd_tid[p]]),
            .arch    (rd_addr[p]),
            .idx     (r_idx[p]),
            .is_zero (r_zero[p])
        );

        always_comb begin
            rd_data[p] = mem_q[r_idx[p]];
            for (int k = 0; k < NWR; k++) begin
                if (w_act[k] && w_idx[k] == r_idx[p]) begin
                    rd_data[p] = wr_data[k];
                end
            end
            if (r_zero[p]) begin
                rd_data[p] = '0;
            end
        end

        p_zero_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr[p] == 5'd0) |-> (rd_data[p] == '0));
    end

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_ovf && win_unf));

endmodule

// File: tb/test_mt_window_regfile.sv
module test_mt_window_regfile;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [2:0][1:0]  rd_tid;
    logic [2:0][4:0]  rd_addr;
    logic [2:0][31:0] rd_data;
    logic [1:0]       wr_en;
    logic [1:0][1:0]  wr_tid;
    logic [1:0][4:0]  wr_addr;
    logic [1:0][31:0] wr_data;
    logic             win_valid;
    logic [1:0]       win_tid;
    logic             win_call;
    logic [3:0][2:0]  cur_win;
    logic [3:0]       switch_req;
    logic             win_ovf;
    logic             win_unf;

    mt_window_regfile i_mt_window_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_tid(rd_tid), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_tid(wr_tid), .wr_addr(wr_addr), .wr_data(wr_data),
        .win_valid(win_valid), .win_tid(win_tid), .win_call(win_call),
        .cur_win(cur_win), .switch_req(switch_req),
        .win_ovf(win_ovf), .win_unf(win_unf)
    );

    // next-cycle stimulus, copied onto the ports by step()
    logic [2:0][1:0]  n_rtid;
    logic [2:0][4:0]  n_raddr;
    logic [1:0]       n_wen;
    logic [1:0][1:0]  n_wtid;
    logic [1:0][4:0]  n_waddr;
    logic [1:0][31:0] n_wdata;
    logic             n_cv;
    logic [1:0]       n_ctid;
    logic             n_call;

    // behavioural model: per-window view of every register
    logic [31:0] gm [4][8];
    logic [31:0] wm [4][8][32];
    int          mwin [4];
    logic [3:0]  e_sw;
    logic        e_ovf, e_unf;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic void idle();
        n_rtid = '0; n_raddr = '0; n_wen = '0; n_wtid = '0; n_waddr = '0;
        n_wdata = '0; n_cv = 1'b0; n_ctid = '0; n_call = 1'b0;
    endfunction

    function automatic void mwrite(input int t, input int r, input logic [31:0] d);
        int w;
        w = mwin[t];
        if (r == 0) return;
        if (r < 8) begin
            gm[t][r] = d;
        end else begin
            wm[t][w][r] = d;
            if (r < 16 && w < 7) wm[t][w + 1][r + 16] = d;
            if (r >= 24 && w > 0) wm[t][w - 1][r - 16] = d;
        end
    endfunction

    function automatic logic [31:0] mread(input int t, input int r);
        if (r == 0) return 32'h0;
        if (r < 8) return gm[t][r];
        return wm[t][mwin[t]][r];
    endfunction

    task automatic step(input string rtag);
        @(negedge clk);
        for (int t = 0; t < 4; t++) begin
            check("R4", 32'(cur_win[t]), 32'(mwin[t]));
            check("R5", 32'(switch_req[t]), 32'(e_sw[t]));
        end
        check("R7", 32'(win_ovf), 32'(e_ovf));
        check("R7", 32'(win_unf), 32'(e_unf));
        rd_tid = n_rtid; rd_addr = n_raddr; wr_en = n_wen; wr_tid = n_wtid;
        wr_addr = n_waddr; wr_data = n_wdata; win_valid = n_cv; win_tid = n_ctid;
        win_call = n_call;
        #1;
        for (int k = 0; k < 2; k++) begin
            if (n_wen[k]) mwrite(int'(n_wtid[k]), int'(n_waddr[k]), n_wdata[k]);
        end
        for (int p = 0; p < 3; p++) begin
            check((n_raddr[p] == 5'd0) ? "R6" : rtag, rd_data[p],
                  mread(int'(n_rtid[p]), int'(n_raddr[p])));
        end
        e_sw = '0; e_ovf = 1'b0; e_unf = 1'b0;
        if (n_cv) begin
            if (n_call) begin
                if (mwin[n_ctid] == 7) e_ovf = 1'b1;
                else begin mwin[n_ctid]++; e_sw[n_ctid] = 1'b1; end
            end else begin
                if (mwin[n_ctid] == 0) e_unf = 1'b1;
                else begin mwin[n_ctid]--; e_sw[n_ctid] = 1'b1; end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 4; t++) begin
            mwin[t] = 0;
            for (int r = 0; r < 8; r++) gm[t][r] = '0;
            for (int w = 0; w < 8; w++)
                for (int r = 0; r < 32; r++) wm[t][w][r] = '0;
        end
        e_sw = '0; e_ovf = 1'b0; e_unf = 1'b0;
        idle();
        rd_tid = '0; rd_addr = '0; wr_en = '0; wr_tid = '0; wr_addr = '0;
        wr_data = '0; win_valid = 1'b0; win_tid = '0; win_call = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset contents
        idle(); n_raddr[0] = 5'd5; n_raddr[1] = 5'd17; n_raddr[2] = 5'd30;
        step("R11");

        // R3: same register number in two threads
        idle();
        n_wen = 2'b11; n_wtid[0] = 2'd0; n_wtid[1] = 2'd1;
        n_waddr[0] = 5'd9; n_waddr[1] = 5'd9;
        n_wdata[0] = 32'hAAAA_0001; n_wdata[1] = 32'hBBBB_0002;
        step("R1");
        idle();
        n_rtid[0] = 2'd0; n_rtid[1] = 2'd1; n_rtid[2] = 2'd2;
        n_raddr[0] = 5'd9; n_raddr[1] = 5'd9; n_raddr[2] = 5'd9;
        step("R3");

        // R10: both ports on one location, port 1 wins
        idle();
        n_wen = 2'b11; n_wtid[0] = 2'd2; n_wtid[1] = 2'd2;
        n_waddr[0] = 5'd20; n_waddr[1] = 5'd20;
        n_wdata[0] = 32'hC0C0_C0C0; n_wdata[1] = 32'hC1C1_C1C1;
        n_rtid[0] = 2'd2; n_raddr[0] = 5'd20;
        step("R10");
        idle(); n_rtid[0] = 2'd2; n_raddr[0] = 5'd20;
        step("R10");

        // R9: same-cycle bypass
        idle();
        n_wen = 2'b01; n_wtid[0] = 2'd3; n_waddr[0] = 5'd3; n_wdata[0] = 32'hD00D_0003;
        n_rtid[1] = 2'd3; n_raddr[1] = 5'd3;
        step("R9");

        // R2: write port 1 alone, visible next cycle
        idle();
        n_wen = 2'b10; n_wtid[1] = 2'd1; n_waddr[1] = 5'd17; n_wdata[1] = 32'hEEEE_1717;
        step("R1");
        idle(); n_rtid[2] = 2'd1; n_raddr[2] = 5'd17;
        step("R2");

        // R6: register 0 ignores writes
        idle();
        n_wen = 2'b11; n_waddr[0] = 5'd0; n_waddr[1] = 5'd0;
        n_wdata[0] = 32'hFFFF_FFFF; n_wdata[1] = 32'h1234_5678;
        step("R6");
        idle();
        step("R6");

        // R8: outs of window 0 become ins of window 1; globals stay
        idle();
        n_wen = 2'b11; n_wtid[0] = 2'd2; n_wtid[1] = 2'd2;
        n_waddr[0] = 5'd10; n_waddr[1] = 5'd1;
        n_wdata[0] = 32'h0A0A_1010; n_wdata[1] = 32'h6161_0001;
        step("R1");
        idle(); n_cv = 1'b1; n_ctid = 2'd2; n_call = 1'b1;
        step("R1");
        idle();
        n_rtid = {2'd2, 2'd2, 2'd2};
        n_raddr[0] = 5'd26; n_raddr[1] = 5'd1; n_raddr[2] = 5'd18;
        step("R8");

        // R12: write and call in the same cycle use the old window
        idle();
        n_wen = 2'b01; n_wtid[0] = 2'd3; n_waddr[0] = 5'd12; n_wdata[0] = 32'h1212_3333;
        n_cv = 1'b1; n_ctid = 2'd3; n_call = 1'b1;
        step("R12");
        idle();
        n_rtid = {2'd3, 2'd3, 2'd3};
        n_raddr[0] = 5'd28; n_raddr[1] = 5'd12; n_raddr[2] = 5'd3;
        step("R12");

        // R7: underflow at window 0, overflow at window 7
        idle(); n_cv = 1'b1; n_ctid = 2'd0; n_call = 1'b0;
        step("R7");
        for (int i = 0; i < 8; i++) begin
            idle(); n_cv = 1'b1; n_ctid = 2'd1; n_call = 1'b1;
            step("R7");
        end
        idle();
        step("R7");

        // random traffic over all threads, windows and registers
        for (int i = 0; i < 4000; i++) begin
            for (int p = 0; p < 3; p++) begin
                n_rtid[p]  = 2'($urandom_range(0, 3));
                n_raddr[p] = 5'($urandom_range(0, 31));
            end
            for (int k = 0; k < 2; k++) begin
                n_wen[k]   = 1'($urandom_range(0, 1));
                n_wtid[k]  = 2'($urandom_range(0, 3));
                n_waddr[k] = 5'($urandom_range(0, 31));
                n_wdata[k] = $urandom;
            end
            if ($urandom_range(0, 3) == 0) begin
                n_wtid[1] = n_wtid[0]; n_waddr[1] = n_waddr[0];
            end
            if ($urandom_range(0, 2) == 0) begin
                n_rtid[0] = n_wtid[0]; n_raddr[0] = n_waddr[0];
            end
            n_cv   = ($urandom_range(0, 2) == 0);
            n_ctid = 2'($urandom_range(0, 3));
            n_call = 1'($urandom_range(0, 1));
            step("R1");
        end
        idle();
        step("R1");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule